// File: doc/BRIEF.md
# Macrocell Register Preload and Security Controller

This block wraps the state registers of an eight-output programmable logic core with the control logic that sits outside the product-term array. It brings the registers to a known all-low state when a power-up reset request arrives. After that request it ignores the array clock enable for a fixed settling window, so that input setup is met before the first real capture. Test equipment can force any pattern into the registers with a preload command.

The block also holds the configuration fuse words, a 64-bit user signature organised as eight bytes, and a security fuse. Once the security fuse is set, fuse-word verify reads, fuse-word writes and register preloads are refused, and each refusal raises a one-cycle error pulse. The signature stays readable and writable. Only a full erase removes the security fuse. The erase also blanks the fuse words and leaves the signature as it was. Non-volatile storage is modelled with registers, and the supply-voltage monitor is reduced to the `por_req` input.

Top module: `pld_ctl_top`

## Requirements
- R1: A `por_req` pulse clears every bit of `q` to 0 at the next clock edge, with priority over preload and clock enable. `out_n` is always the bitwise inverse of `q`, so every registered output reads high after a reset request.
- R2: After the block's own reset and after every `por_req` edge, `clk_en` has no effect for HOLDOFF_CYC clock edges. The first edge that honours it is edge HOLDOFF_CYC+1 after the request.
- R3: Once the settling window has passed, an edge with `clk_en`=1 loads `d_in` into `q`. An edge with `clk_en`=0 leaves `q` unchanged.
- R4: While unsecured, `pre_en`=1 loads `pre_val` into `q` at the next edge. This overrides `clk_en`, and it also works inside the settling window.
- R5: `wr_en` with `wr_sel`=0 writes `wr_data` into fuse word `wr_addr`. `rd_en` with `rd_sel`=0 returns that word on `rd_data`, with `rd_valid`=1, in the cycle after the request. `rd_valid` is 0 in the cycle after a cycle without `rd_en`.
- R6: With `wr_sel`/`rd_sel`=1, the request addresses the signature. Only the low 3 bits of the address choose the byte. Signature reads and writes work whether or not the security fuse is set.
- R7: `sec_prog`=1 sets `secured` at the next edge. Requests made in the same cycle as `sec_prog` still see the unsecured state.
- R8: A fuse-word read while secured returns `rd_data`=0 with `rd_valid`=1 and `rej_err`=1. `rej_err` returns to 0 in the following cycle if nothing else is refused.
- R9: While secured, a preload leaves `q` unchanged and a fuse-word write is refused. Each of these raises `rej_err` in the next cycle.
- R10: `erase`=1 clears `secured` and all fuse words at the next edge and leaves the signature intact. When `sec_prog` and `erase` arrive together, erase wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| por_req | input | 1 | Power-up reset request: clears registers, restarts the settling window |
| clk_en | input | 1 | Array clock enable for the macrocell registers |
| d_in | input | 8 | Next-state data from the product-term array |
| pre_en | input | 1 | Preload command |
| pre_val | input | 8 | Pattern forced by a preload |
| wr_en | input | 1 | Storage write request |
| wr_sel | input | 1 | Write target: 0 fuse words, 1 signature |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Storage read request |
| rd_sel | input | 1 | Read target: 0 fuse words, 1 signature |
| rd_addr | input | 4 | Read address |
| sec_prog | input | 1 | Program the security fuse |
| erase | input | 1 | Full erase of fuse words and security fuse |
| q | output | 8 | Macrocell register states |
| out_n | output | 8 | Inverted register outputs |
| secured | output | 1 | Security fuse state |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response data |
| rej_err | output | 1 | One-cycle pulse for a refused request |

## Verification
Every result of this block comes one register after its request. `q`, `secured`, `rd_valid`, `rd_data` and `rej_err` all change at the first edge after the command, while `out_n` follows `q` with no delay. The one exception is the clock enable after a reset request, which is counted out to edge HOLDOFF_CYC+1. The bench drives every input at the falling edge and moves exactly one rising edge before it compares outputs. The settling test counts the edges one at a time and checks that `q` holds at each of the first HOLDOFF_CYC edges and changes at the next. Same-cycle orderings, such as a read alongside `sec_prog`, and `erase` with `sec_prog`, are issued together so that the cycle in which each takes effect is pinned down.

// File: rtl/pld_ctl_pkg.sv
package pld_ctl_pkg;
  typedef enum logic {
    STORE_FUSE = 1'b0,
    STORE_SIG  = 1'b1
  } store_sel_e;
endpackage

// File: rtl/pld_rst_sync.sv
module pld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/pld_holdoff.sv
module pld_holdoff #(
  parameter int HOLDOFF_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por,
  output logic clk_ok
);
  localparam int CNT_W = (HOLDOFF_CYC < 1) ? 1 : $clog2(HOLDOFF_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLDOFF_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (por) begin
      cnt_nxt = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_LOAD;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  assign clk_ok = (cnt_q == '0);

  generate
    if (HOLDOFF_CYC > 0) begin : g_chk
      assert_holdoff_restart_R2: assert property (
        @(posedge clk) disable iff (!rst_n) por |=> !clk_ok
      );
    end
  endgenerate
endmodule

// File: rtl/pld_mc_regs.sv
module pld_mc_regs #(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por,
  input  logic            pre_go,
  input  logic [NREG-1:0] pre_val,
  input  logic            clk_ok,
  input  logic            clk_en,
  input  logic [NREG-1:0] d_in,
  output logic [NREG-1:0] q
);
  logic [NREG-1:0] q_nxt;
  logic            cap_go;

  assign cap_go = clk_ok && clk_en;

  always_comb begin
    q_nxt = q;
    if (por) begin
      q_nxt = '0;
    end else if (pre_go) begin
      q_nxt = pre_val;
    end else if (cap_go) begin
      q_nxt = d_in;
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[gi] <= 1'b0;
      end else begin
        q[gi] <= q_nxt[gi];
      end
    end
  end

  assert_por_clears_R1: assert property (
    @(posedge clk) disable iff (!rst_n) por |=> (q == '0)
  );
  assert_holdoff_blocks_R2: assert property (
    @(posedge clk) disable iff (!rst_n) (!clk_ok && !por && !pre_go) |=> $stable(q)
  );
  assert_preload_loads_R4: assert property (
    @(posedge clk) disable iff (!rst_n) (pre_go && !por) |=> (q == $past(pre_val))
  );
endmodule

// File: rtl/pld_cfg_store.sv
module pld_cfg_store
  import pld_ctl_pkg::*;
#(
  parameter int FUSE_WORDS = 16,
  parameter int SIG_BYTES  = 8,
  parameter int WORD_W     = 8,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_prog,
  input  logic              erase,
  input  logic              pre_req,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              secured,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rej_err
);
  localparam int SIG_AW = (SIG_BYTES < 2) ? 1 : $clog2(SIG_BYTES);
  localparam logic [ADDR_W:0] FUSE_LIM = (ADDR_W + 1)'(FUSE_WORDS);

  logic [WORD_W-1:0] fuse_mem [FUSE_WORDS];
  logic [WORD_W-1:0] fuse_nxt [FUSE_WORDS];
  logic [WORD_W-1:0] sig_mem  [SIG_BYTES];
  logic [WORD_W-1:0] sig_nxt  [SIG_BYTES];
  logic              sec_nxt;
  logic              rd_valid_nxt;
  logic [WORD_W-1:0] rd_data_nxt;
  logic              err_nxt;

  store_sel_e wsel;
  store_sel_e rsel;
  logic       wr_fuse_hit;
  logic       rd_fuse_hit;
  logic [SIG_AW-1:0] wr_sig_idx;
  logic [SIG_AW-1:0] rd_sig_idx;

  assign wsel        = store_sel_e'(wr_sel);
  assign rsel        = store_sel_e'(rd_sel);
  assign wr_fuse_hit = ({1'b0, wr_addr} < FUSE_LIM);
  assign rd_fuse_hit = ({1'b0, rd_addr} < FUSE_LIM);
  assign wr_sig_idx  = wr_addr[SIG_AW-1:0];
  assign rd_sig_idx  = rd_addr[SIG_AW-1:0];

  always_comb begin
    sec_nxt = secured;
    if (erase) begin
      sec_nxt = 1'b0;
    end else if (sec_prog) begin
      sec_nxt = 1'b1;
    end

    for (int i = 0; i < FUSE_WORDS; i++) begin
      fuse_nxt[i] = erase ? '0 : fuse_mem[i];
    end
    if (!erase && wr_en && (wsel == STORE_FUSE) && !secured && wr_fuse_hit) begin
      fuse_nxt[wr_addr] = wr_data;
    end

    for (int i = 0; i < SIG_BYTES; i++) begin
      sig_nxt[i] = sig_mem[i];
    end
    if (wr_en && (wsel == STORE_SIG)) begin
      sig_nxt[wr_sig_idx] = wr_data;
    end

    rd_valid_nxt = rd_en;
    rd_data_nxt  = '0;
    if (rd_en) begin
      if (rsel == STORE_SIG) begin
        rd_data_nxt = sig_mem[rd_sig_idx];
      end else if (!secured && rd_fuse_hit) begin
        rd_data_nxt = fuse_mem[rd_addr];
      end
    end

    err_nxt = secured && ((rd_en && (rsel == STORE_FUSE)) ||
                          (wr_en && (wsel == STORE_FUSE)) ||
                          pre_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secured  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rej_err  <= 1'b0;
    end else begin
      secured  <= sec_nxt;
      rd_valid <= rd_valid_nxt;
      rd_data  <= rd_data_nxt;
      rej_err  <= err_nxt;
    end
  end

  for (genvar gw = 0; gw < FUSE_WORDS; gw++) begin : g_fuse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fuse_mem[gw] <= '0;
      end else begin
        fuse_mem[gw] <= fuse_nxt[gw];
      end
    end
  end

  for (genvar gs = 0; gs < SIG_BYTES; gs++) begin : g_sig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sig_mem[gs] <= '0;
      end else begin
        sig_mem[gs] <= sig_nxt[gs];
      end
    end
  end

  assert_fuse_sticky_R7: assert property (
    @(posedge clk) disable iff (!rst_n) (!sec_prog && !erase) |=> $stable(secured)
  );
  assert_fuse_sets_R7: assert property (
    @(posedge clk) disable iff (!rst_n) (sec_prog && !erase) |=> secured
  );
  assert_erase_unlocks_R10: assert property (
    @(posedge clk) disable iff (!rst_n) erase |=> !secured
  );
  assert_read_refused_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_sel == 1'b0) && secured) |=> (rd_valid && rej_err && (rd_data == '0))
  );
  assert_read_valid_R5: assert property (
    @(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid
  );
  assert_no_spurious_err_R9: assert property (
    @(posedge clk) disable iff (!rst_n) !secured |=> !rej_err
  );
endmodule

// File: rtl/pld_ctl_top.sv
module pld_ctl_top #(
  parameter int NREG        = 8,
  parameter int FUSE_WORDS  = 16,
  parameter int SIG_BYTES   = 8,
  parameter int WORD_W      = 8,
  parameter int HOLDOFF_CYC = 12,
  parameter int ADDR_W      = (FUSE_WORDS < 2) ? 1 : $clog2(FUSE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_req,
  input  logic              clk_en,
  input  logic [NREG-1:0]   d_in,
  input  logic              pre_en,
  input  logic [NREG-1:0]   pre_val,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              sec_prog,
  input  logic              erase,
  output logic [NREG-1:0]   q,
  output logic [NREG-1:0]   out_n,
  output logic              secured,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rej_err
);
  logic rst_int_n;
  logic clk_ok;
  logic pre_req;
  logic pre_go;

  assign pre_req = pre_en && !por_req;
  assign pre_go  = pre_req && !secured;

  pld_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pld_holdoff #(
    .HOLDOFF_CYC (HOLDOFF_CYC)
  ) u_holdoff (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .por    (por_req),
    .clk_ok (clk_ok)
  );

  pld_mc_regs #(
    .NREG (NREG)
  ) u_mc_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .por     (por_req),
    .pre_go  (pre_go),
    .pre_val (pre_val),
    .clk_ok  (clk_ok),
    .clk_en  (clk_en),
    .d_in    (d_in),
    .q       (q)
  );

  pld_cfg_store #(
    .FUSE_WORDS (FUSE_WORDS),
    .SIG_BYTES  (SIG_BYTES),
    .WORD_W     (WORD_W),
    .ADDR_W     (ADDR_W)
  ) u_cfg_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sec_prog (sec_prog),
    .erase    (erase),
    .pre_req  (pre_req),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rd_addr  (rd_addr),
    .secured  (secured),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rej_err  (rej_err)
  );

  assign out_n = ~q;

  assert_out_inverts_R1: assert property (
    @(posedge clk) disable iff (!rst_int_n) out_n == ~q
  );
endmodule

// File: tb/pld_ctl_top_tb.sv
module pld_ctl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;

  logic       clk;
  logic       rst_n;
  logic       por_req;
  logic       clk_en;
  logic [7:0] d_in;
  logic       pre_en;
  logic [7:0] pre_val;
  logic       wr_en;
  logic       wr_sel;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_en;
  logic       rd_sel;
  logic [3:0] rd_addr;
  logic       sec_prog;
  logic       erase;
  logic [7:0] q;
  logic [7:0] out_n;
  logic       secured;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rej_err;

  int n_cmp;
  int n_bad;
  bit done;

  pld_ctl_top #(
    .HOLDOFF_CYC (HOLD)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_req  (por_req),
    .clk_en   (clk_en),
    .d_in     (d_in),
    .pre_en   (pre_en),
    .pre_val  (pre_val),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rd_addr  (rd_addr),
    .sec_prog (sec_prog),
    .erase    (erase),
    .q        (q),
    .out_n    (out_n),
    .secured  (secured),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rej_err  (rej_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    por_req = 0; clk_en = 0; pre_en = 0; wr_en = 0; rd_en = 0;
    sec_prog = 0; erase = 0;
  endtask

  task automatic write_word(input logic sel, input logic [3:0] a, input logic [7:0] v);
    wr_en = 1; wr_sel = sel; wr_addr = a; wr_data = v;
    step();
    wr_en = 0;
  endtask

  task automatic read_word(input string req, input logic sel, input logic [3:0] a,
                           input logic [7:0] exp_d, input logic exp_err);
    rd_en = 1; rd_sel = sel; rd_addr = a;
    step();
    rd_en = 0;
    check(req, "rd_valid", 32'(rd_valid), 32'd1);
    check(req, "rd_data", 32'(rd_data), 32'(exp_d));
    check(req, "rej_err", 32'(rej_err), 32'(exp_err));
  endtask

  task automatic wait_settle();
    repeat (HOLD + 2) step();
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle();
    d_in = 0; pre_val = 0; wr_sel = 0; wr_addr = 0; wr_data = 0; rd_sel = 0; rd_addr = 0;
    repeat (3) step();
    check("R1", "q after reset", 32'(q), 32'h00);
    check("R1", "out_n after reset", 32'(out_n), 32'hFF);
    check("R7", "secured after reset", 32'(secured), 32'd0);
    check("R5", "rd_valid idle", 32'(rd_valid), 32'd0);
    rst_n = 1;
    repeat (2) step();
  endtask

  task automatic t_holdoff();
    por_req = 1; clk_en = 1; d_in = 8'hA5;
    step();
    por_req = 0;
    check("R1", "q after por", 32'(q), 32'h00);
    for (int k = 1; k <= HOLD; k++) begin
      step();
      check("R2", "q held in window", 32'(q), 32'h00);
    end
    step();
    check("R2", "first honoured edge", 32'(q), 32'hA5);
    check("R1", "out_n inverse", 32'(out_n), 32'h5A);
    clk_en = 0;
  endtask

  task automatic t_capture();
    clk_en = 1; d_in = 8'h5A;
    step();
    check("R3", "capture", 32'(q), 32'h5A);
    clk_en = 0; d_in = 8'hFF;
    step();
    check("R3", "hold without enable", 32'(q), 32'h5A);
    check("R1", "out_n inverse", 32'(out_n), 32'hA5);
  endtask

  task automatic t_preload();
    clk_en = 1; d_in = 8'h11; pre_en = 1; pre_val = 8'h3C;
    step();
    pre_en = 0;
    check("R4", "preload beats clk_en", 32'(q), 32'h3C);
    step();
    check("R3", "capture after preload", 32'(q), 32'h11);
    clk_en = 0; por_req = 1;
    step();
    por_req = 0; pre_en = 1; pre_val = 8'hC3;
    step();
    pre_en = 0;
    check("R4", "preload inside window", 32'(q), 32'hC3);
    por_req = 1; pre_en = 1; pre_val = 8'h77; clk_en = 1; d_in = 8'h99;
    step();
    por_req = 0; pre_en = 0; clk_en = 0;
    check("R1", "por beats preload", 32'(q), 32'h00);
    wait_settle();
  endtask

  task automatic t_fuse();
    write_word(1'b0, 4'd3, 8'h9E);
    write_word(1'b0, 4'd15, 8'h42);
    read_word("R5", 1'b0, 4'd3, 8'h9E, 1'b0);
    step();
    check("R5", "rd_valid drops", 32'(rd_valid), 32'd0);
    read_word("R5", 1'b0, 4'd15, 8'h42, 1'b0);
  endtask

  task automatic t_sig();
    write_word(1'b1, 4'd1, 8'h77);
    write_word(1'b1, 4'd7, 8'hE1);
    read_word("R6", 1'b1, 4'd9, 8'h77, 1'b0);
    read_word("R6", 1'b1, 4'd7, 8'hE1, 1'b0);
  endtask

  task automatic t_secure();
    clk_en = 1; d_in = 8'h69;
    step();
    clk_en = 0;
    sec_prog = 1; rd_en = 1; rd_sel = 0; rd_addr = 4'd3;
    step();
    sec_prog = 0; rd_en = 0;
    check("R7", "secured next edge", 32'(secured), 32'd1);
    check("R7", "same-cycle read allowed", 32'(rd_data), 32'h9E);
    check("R7", "same-cycle read no error", 32'(rej_err), 32'd0);
    read_word("R8", 1'b0, 4'd3, 8'h00, 1'b1);
    step();
    check("R8", "error lasts one cycle", 32'(rej_err), 32'd0);
    read_word("R6", 1'b1, 4'd7, 8'hE1, 1'b0);
    pre_en = 1; pre_val = 8'hFF;
    step();
    pre_en = 0;
    check("R9", "preload refused q", 32'(q), 32'h69);
    check("R9", "preload refused err", 32'(rej_err), 32'd1);
    write_word(1'b0, 4'd3, 8'h00);
    check("R9", "fuse write refused err", 32'(rej_err), 32'd1);
    write_word(1'b1, 4'd2, 8'hB4);
    check("R6", "signature write while secured no err", 32'(rej_err), 32'd0);
    read_word("R6", 1'b1, 4'd2, 8'hB4, 1'b0);
  endtask

  task automatic t_erase();
    erase = 1; sec_prog = 1;
    step();
    erase = 0; sec_prog = 0;
    check("R10", "erase beats sec_prog", 32'(secured), 32'd0);
    read_word("R10", 1'b0, 4'd3, 8'h00, 1'b0);
    read_word("R10", 1'b0, 4'd15, 8'h00, 1'b0);
    read_word("R10", 1'b1, 4'd1, 8'h77, 1'b0);
    write_word(1'b0, 4'd3, 8'h5D);
    read_word("R5", 1'b0, 4'd3, 8'h5D, 1'b0);
    pre_en = 1; pre_val = 8'h81;
    step();
    pre_en = 0;
    check("R4", "preload after erase", 32'(q), 32'h81);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done = 0;
    t_reset();
    t_holdoff();
    t_capture();
    t_preload();
    t_fuse();
    t_sig();
    t_secure();
    t_erase();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule